// File: doc/BRIEF.md
# Point-List Scan Sequencer with Sample FIFO

This block runs acquisition in the background, with no host involvement per sample. The host first loads a list of 16-bit scan entries. Each entry names an analog channel, single-ended or differential mode, an input range, and a 4-bit select and a 3-bit gain for an external sub-multiplexer. A priming read then arms the sequencer. From then on, each accepted conversion trigger applies the next entry to the converter outputs and pulses a start. When the converter reports done, the 12-bit result is tagged with the entry's select bits and pushed into a data FIFO. The host drains that FIFO oldest-first. After the last entry the list starts again at the first, so the scan repeats indefinitely.

Triggers come from a counter tick or from the rising edge of an external pin, each gated by its own option bit. Two option bits are write-one strobes that empty the point list or the data FIFO. A status byte reports the busy state and the external pin level. It also reports full, more-than-half and empty for both FIFOs, and each of those flags reads 0 when its condition holds. A half-full interrupt and an error interrupt are level requests. The error is a sticky flag, set by an underflow read or by an overflow at conversion completion, and a status read clears it.

Top module: `scan_seq_top`

## Requirements
- R1: An entry word carries the sub-multiplexer select in bits 15:12, a spare bit 11, the gain in bits 10:8, the channel in bits 7:4, the differential flag in bit 3 and the range in bits 2:0. While a conversion runs, the converter and sub-multiplexer outputs present the fields of the entry that started it.
- R2: No conversion starts after reset or after a point-list clear until a priming pulse arrives. The priming pulse rewinds the scan to the first entry, and `pl_rd_word` shows the entry the next trigger will apply.
- R3: Each accepted trigger causes exactly one `conv_start` pulse, one cycle wide, in the next cycle, and advances the scan by one entry. After the last loaded entry the scan wraps to entry 0.
- R4: When `conv_done` arrives during a conversion, the word {select[3:0], result[11:0]} is appended to the data FIFO. `dat_rd_word` always shows the oldest stored word, and `dat_rd_en` removes it.
- R5: A trigger is counter tick when option bit 0 is set, or a rising edge of `ext_pin` when option bit 7 is set. A trigger that arrives while a conversion is busy or while the point list is empty is ignored and does not advance the scan.
- R6: Writing an option byte with bit 6 set empties the point list and disarms the sequencer. Writing one with bit 5 set empties the data FIFO. Both bits are strobes and read back 0 on `opt_rd_byte`. Bits 7, 4, 3, 2, 1 and 0 are stored.
- R7: The status byte is {busy, list full_n, list more-than-half_n, list empty_n, data full_n, data more-than-half_n, data empty_n, ext_pin}. "More than half" means a count greater than DEPTH/2. Reset status is 8'h6C.
- R8: A completion while the data FIFO holds DEPTH words drops the sample and sets the error flag. A read while the data FIFO is empty changes nothing and sets the error flag.
- R9: `irq_err` is high while option bit 1 is set and the error flag is set. Reading the status byte clears the flag, unless a new error occurs in the same cycle.
- R10: `irq_half` is high while option bit 2 is set and the data count is greater than DEPTH/2. It drops once the count is DEPTH/2 or less.
- R11: A point-list write while the list holds DEPTH entries is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pl_wr_en | input | 1 | Append `pl_wr_word` to the point list |
| pl_wr_word | input | 16 | Scan entry to append |
| pl_prime | input | 1 | Priming read pulse: rewind and arm |
| pl_rd_word | output | 16 | Entry at the current scan position |
| opt_wr_en | input | 1 | Write the option byte |
| opt_wr_byte | input | 8 | Option byte value |
| opt_rd_byte | output | 8 | Stored option bits |
| stat_rd_en | input | 1 | Status read pulse (clears the error flag) |
| status | output | 8 | Status byte |
| dat_rd_en | input | 1 | Pop the oldest sample |
| dat_rd_word | output | 16 | Oldest stored sample |
| ctr_tick | input | 1 | Counter trigger pulse |
| ext_pin | input | 1 | External trigger pin |
| conv_start | output | 1 | One-cycle converter start |
| conv_chan | output | 4 | Channel for the conversion |
| conv_diff | output | 1 | Differential mode |
| conv_rng | output | 3 | Range code |
| submux_sel | output | 4 | Sub-multiplexer select |
| submux_gain | output | 3 | Sub-multiplexer gain |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 12 | Converter result, valid with `conv_done` |
| irq_half | output | 1 | Data FIFO more-than-half request |
| irq_err | output | 1 | Error request |

## Verification
The hardest situation to reach from the ports is a conversion that completes into a data FIFO that is already full. The bench sets this up by running DEPTH conversions without draining, then fires one more. Its scoreboard models the occupancy, so it knows that this sample must never appear when the FIFO is later drained. The replay wrap at a full point list is reached the same way. The bench loads one entry more than the list holds and checks that the conversion after the last entry uses entry 0, which shows the extra write was dropped.

// File: rtl/sl_pkg.sv
package sl_pkg;

  typedef struct packed {
    logic [3:0] sel;
    logic       spare;
    logic [2:0] gain;
    logic [3:0] chan;
    logic       diff;
    logic [2:0] rng;
  } scan_entry_t;

  localparam int OPT_EXT_EN  = 7;
  localparam int OPT_CLR_PL  = 6;
  localparam int OPT_CLR_DAT = 5;
  localparam int OPT_HALF_EN = 2;
  localparam int OPT_ERR_EN  = 1;
  localparam int OPT_CTR_EN  = 0;
  localparam logic [7:0] OPT_KEEP_MASK = 8'h9F;

  // {full_n, more_than_half_n, empty_n}
  function automatic logic [2:0] level_flags_n(input int unsigned cnt,
                                               input int unsigned depth);
    return {cnt != depth, !(cnt > depth / 2), cnt != 0};
  endfunction

  function automatic logic [7:0] pack_status(input logic busy,
                                             input logic [2:0] pl_f,
                                             input logic [2:0] dat_f,
                                             input logic ext);
    return {busy, pl_f, dat_f, ext};
  endfunction

endpackage

// File: rtl/sl_point_list.sv
module sl_point_list #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [15:0]       wr_word,
  input  logic              rewind,
  input  logic              advance,
  output logic [15:0]       head_word,
  output logic [CW-1:0]     count
);
  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] rd_idx;
  logic [CW-1:0] nxt_idx;
  logic          wr_ok;

  assign wr_ok     = wr_en && !clr && (count < CW'(DEPTH));
  assign nxt_idx   = CW'(rd_idx) + CW'(1);
  assign head_word = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[count[AW-1:0]] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      rd_idx <= '0;
    end else if (clr) begin
      count  <= '0;
      rd_idx <= '0;
    end else begin
      if (wr_ok) count <= count + CW'(1);
      if (rewind)       rd_idx <= '0;
      else if (advance) rd_idx <= (nxt_idx >= count) ? '0 : nxt_idx[AW-1:0];
    end
  end
endmodule

// File: rtl/sl_data_fifo.sv
module sl_data_fifo #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [15:0]   push_word,
  input  logic          pop,
  output logic [15:0]   head_word,
  output logic [CW-1:0] count
);
  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign push_ok   = push && !clr && (count != CW'(DEPTH));
  assign pop_ok    = pop && !clr && (count != '0);
  assign head_word = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/sl_seq_ctrl.sv
module sl_seq_ctrl
  import sl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_ev,
  input  logic        prime,
  input  logic        pl_clr,
  input  logic        pl_has_entry,
  input  logic [15:0] head_word,
  input  logic        conv_done,
  input  logic [11:0] conv_result,
  output logic        conv_start,
  output logic        busy,
  output logic        armed,
  output logic        advance,
  output scan_entry_t cur,
  output logic        sample_done,
  output logic [15:0] sample_word
);
  logic trig_ok;

  assign trig_ok     = trig_ev && armed && !busy && pl_has_entry && !pl_clr;
  assign advance     = trig_ok;
  assign sample_done = conv_done && busy;
  assign sample_word = {cur.sel, conv_result};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      busy       <= 1'b0;
      conv_start <= 1'b0;
      cur        <= '0;
    end else begin
      conv_start <= trig_ok;
      if (pl_clr)     armed <= 1'b0;
      else if (prime) armed <= 1'b1;
      if (trig_ok) begin
        busy <= 1'b1;
        cur  <= scan_entry_t'(head_word);
      end else if (sample_done) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import sl_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pl_wr_en,
  input  logic [15:0] pl_wr_word,
  input  logic        pl_prime,
  output logic [15:0] pl_rd_word,
  input  logic        opt_wr_en,
  input  logic [7:0]  opt_wr_byte,
  output logic [7:0]  opt_rd_byte,
  input  logic        stat_rd_en,
  output logic [7:0]  status,
  input  logic        dat_rd_en,
  output logic [15:0] dat_rd_word,
  input  logic        ctr_tick,
  input  logic        ext_pin,
  output logic        conv_start,
  output logic [3:0]  conv_chan,
  output logic        conv_diff,
  output logic [2:0]  conv_rng,
  output logic [3:0]  submux_sel,
  output logic [2:0]  submux_gain,
  input  logic        conv_done,
  input  logic [11:0] conv_result,
  output logic        irq_half,
  output logic        irq_err
);
  logic [7:0]    opt_q;
  logic          ext_q, ext_rise, trig_ev;
  logic          clr_pl, clr_dat;
  logic          busy, armed, advance, sample_done, err_flag, err_set;
  logic [15:0]   sample_word;
  logic [CW-1:0] pl_count, data_count;
  logic [2:0]    pl_flags_n, dat_flags_n;
  scan_entry_t   cur;

  assign clr_pl   = opt_wr_en && opt_wr_byte[OPT_CLR_PL];
  assign clr_dat  = opt_wr_en && opt_wr_byte[OPT_CLR_DAT];
  assign ext_rise = ext_pin && !ext_q;
  assign trig_ev  = (opt_q[OPT_CTR_EN] && ctr_tick) || (opt_q[OPT_EXT_EN] && ext_rise);
  assign err_set  = (sample_done && data_count == CW'(DEPTH))
                 || (dat_rd_en && data_count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q    <= '0;
      ext_q    <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (opt_wr_en) opt_q <= opt_wr_byte & OPT_KEEP_MASK;
      ext_q <= ext_pin;
      if (err_set)         err_flag <= 1'b1;
      else if (stat_rd_en) err_flag <= 1'b0;
    end
  end

  sl_point_list #(.DEPTH(DEPTH)) pl_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_pl), .wr_en(pl_wr_en), .wr_word(pl_wr_word),
    .rewind(pl_prime), .advance(advance), .head_word(pl_rd_word), .count(pl_count)
  );

  sl_data_fifo #(.DEPTH(DEPTH)) df_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_dat), .push(sample_done), .push_word(sample_word),
    .pop(dat_rd_en), .head_word(dat_rd_word), .count(data_count)
  );

  sl_seq_ctrl seq_i (
    .clk(clk), .rst_n(rst_n), .trig_ev(trig_ev), .prime(pl_prime), .pl_clr(clr_pl),
    .pl_has_entry(pl_count != '0), .head_word(pl_rd_word), .conv_done(conv_done),
    .conv_result(conv_result), .conv_start(conv_start), .busy(busy), .armed(armed),
    .advance(advance), .cur(cur), .sample_done(sample_done), .sample_word(sample_word)
  );

  assign conv_chan   = cur.chan;
  assign conv_diff   = cur.diff;
  assign conv_rng    = cur.rng;
  assign submux_sel  = cur.sel;
  assign submux_gain = cur.gain;
  assign opt_rd_byte = opt_q;

  assign pl_flags_n  = level_flags_n(int'(pl_count), DEPTH);
  assign dat_flags_n = level_flags_n(int'(data_count), DEPTH);
  assign status      = pack_status(busy, pl_flags_n, dat_flags_n, ext_pin);
  assign irq_half    = opt_q[OPT_HALF_EN] && !dat_flags_n[1];
  assign irq_err     = opt_q[OPT_ERR_EN] && err_flag;
endmodule

// File: rtl/sl_seq_checker.sv
module sl_seq_checker #(
  parameter int DEPTH = 2048,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_start,
  input logic          conv_done,
  input logic          busy,
  input logic          armed,
  input logic          err_flag,
  input logic          irq_half,
  input logic          irq_err,
  input logic          half_en,
  input logic          dat_rd_en,
  input logic          clr_dat,
  input logic [7:0]    status,
  input logic [CW-1:0] data_count
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R3
  AST_NO_START_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !conv_start); // R2
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> !conv_start); // R5
  AST_FULL_FLAG_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    !status[3] |-> (!status[2] && status[1])); // R7
  AST_UNDERFLOW_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd_en && !status[1]) |=> err_flag); // R8
  AST_OVERFLOW_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && busy && !status[3] && !dat_rd_en && !clr_dat) |=> $stable(data_count)); // R8
  AST_ERR_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> err_flag); // R9
  AST_HALF_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_half |-> (half_en && !status[2])); // R10
endmodule

bind scan_seq_top sl_seq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
  .busy(busy), .armed(armed), .err_flag(err_flag), .irq_half(irq_half),
  .irq_err(irq_err), .half_en(opt_q[2]), .dat_rd_en(dat_rd_en), .clr_dat(clr_dat),
  .status(status), .data_count(data_count)
);

// File: tb/scan_seq_top_tb_top.sv
module scan_seq_top_tb_top;
  localparam int DEPTH = 16;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pl_wr_en = 0, pl_prime = 0, opt_wr_en = 0, stat_rd_en = 0, dat_rd_en = 0;
  logic ctr_tick = 0, ext_pin = 0, conv_done = 0;
  logic [15:0] pl_wr_word = '0;
  logic [7:0]  opt_wr_byte = '0;
  logic [11:0] conv_result = '0;
  logic [15:0] pl_rd_word, dat_rd_word;
  logic [7:0]  opt_rd_byte, status;
  logic        conv_start, conv_diff, irq_half, irq_err;
  logic [3:0]  conv_chan, submux_sel;
  logic [2:0]  conv_rng, submux_gain;

  always #5 clk = ~clk;

  scan_seq_top #(.DEPTH(DEPTH)) dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  logic [15:0] pl_mem [DEPTH];
  int pl_n = 0, pl_idx = 0, dcnt = 0, starts = 0, nres = 0;
  logic [15:0] exp_ent [$];
  logic [15:0] sb [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat(input bit bz, input int pc, input int dc, input bit ex);
    return {bz, pc != DEPTH, pc <= DEPTH / 2, pc != 0, dc != DEPTH, dc <= DEPTH / 2, dc != 0, ex};
  endfunction

  // converter model and scoreboard producer
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start === 1'b1) begin
        logic [15:0] got, e;
        logic [11:0] res;
        starts++;
        got = {submux_sel, 1'b0, submux_gain, conv_chan, conv_diff, conv_rng};
        if (exp_ent.size() == 0) begin
          chk("R5 unexpected start", 32'(got), 32'hFFFF_FFFF);
          e = got;
        end else begin
          e = exp_ent.pop_front();
          chk("R1 R3 applied entry", 32'(got), 32'(e & 16'hF7FF));
        end
        res = 12'h100 + 12'(nres);
        nres++;
        repeat (LAT) @(negedge clk);
        conv_done = 1'b1;
        conv_result = res;
        if (dcnt < DEPTH) begin
          sb.push_back({e[15:12], res});
          dcnt++;
        end
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  task automatic opt_write(input logic [7:0] b);
    @(negedge clk); opt_wr_byte = b; opt_wr_en = 1'b1;
    @(negedge clk); opt_wr_en = 1'b0;
  endtask

  task automatic pl_write(input logic [15:0] w);
    @(negedge clk); pl_wr_word = w; pl_wr_en = 1'b1;
    @(negedge clk); pl_wr_en = 1'b0;
    if (pl_n < DEPTH) begin pl_mem[pl_n] = w; pl_n++; end
  endtask

  task automatic prime();
    @(negedge clk); pl_prime = 1'b1;
    @(negedge clk); pl_prime = 1'b0;
    pl_idx = 0;
  endtask

  task automatic fire(input bit accepted);
    if (accepted) begin
      exp_ent.push_back(pl_mem[pl_idx]);
      pl_idx = (pl_idx + 1) % pl_n;
    end
    @(negedge clk); ctr_tick = 1'b1;
    @(negedge clk); ctr_tick = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic drain(input string req);
    @(negedge clk);
    if (sb.size() == 0) chk({req, " scoreboard empty"}, 32'(dat_rd_word), 32'hFFFF_FFFF);
    else chk(req, 32'(dat_rd_word), 32'(sb.pop_front()));
    dat_rd_en = 1'b1;
    @(negedge clk); dat_rd_en = 1'b0;
    dcnt--;
  endtask

  task automatic read_status(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, 32'(status), 32'(exp));
    stat_rd_en = 1'b1;
    @(negedge clk); stat_rd_en = 1'b0;
  endtask

  task automatic run_all();
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset status", 32'(status), 32'h6C);
    chk("R9 R10 reset irqs", {30'd0, irq_half, irq_err}, 32'd0);

    opt_write(8'h07);
    chk("R6 option readback", 32'(opt_rd_byte), 32'h07);
    pl_write(16'h3215); pl_write(16'h5A3C); pl_write(16'hC7F6);
    s0 = starts;
    fire(0);
    chk("R2 no start before priming", starts, s0);
    prime();
    chk("R2 head after prime", 32'(pl_rd_word), 32'h3215);
    for (int i = 0; i < 7; i++) fire(1);
    chk("R3 seven starts with wrap", starts, s0 + 7);
    chk("R7 idle status", 32'(status), 32'(exp_stat(0, 3, 7, 0)));

    // back-to-back trigger while busy
    s0 = starts;
    exp_ent.push_back(pl_mem[pl_idx]); pl_idx = (pl_idx + 1) % pl_n;
    @(negedge clk); ctr_tick = 1'b1;
    repeat (2) @(negedge clk); ctr_tick = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 trigger while busy ignored", starts, s0 + 1);

    prime();
    fire(1);
    chk("R10 half irq above half", 32'(irq_half), 32'd1);
    drain("R4 oldest first");
    @(negedge clk);
    chk("R10 half irq drops at half", 32'(irq_half), 32'd0);
    for (int i = 0; i < 8; i++) drain("R4 oldest first");

    // underflow
    @(negedge clk); dat_rd_en = 1'b1;
    @(negedge clk); dat_rd_en = 1'b0;
    chk("R8 underflow error irq", 32'(irq_err), 32'd1);
    read_status("R7 status after drain", exp_stat(0, 3, 0, 0));
    chk("R9 status read clears error", 32'(irq_err), 32'd0);

    // external trigger
    opt_write(8'h86);
    s0 = starts;
    fire(0);
    chk("R5 counter tick disabled", starts, s0);
    exp_ent.push_back(pl_mem[pl_idx]); pl_idx = (pl_idx + 1) % pl_n;
    @(negedge clk); ext_pin = 1'b1;
    repeat (12) @(negedge clk);
    chk("R5 ext rising edge one start", starts, s0 + 1);
    chk("R7 ext pin in status", 32'(status[0]), 32'd1);
    @(negedge clk); ext_pin = 1'b0;

    // fill and overflow
    opt_write(8'h07);
    for (int i = 0; i < DEPTH - 1; i++) fire(1);
    chk("R7 data full status", 32'(status), 32'(exp_stat(0, 3, DEPTH, 0)));
    chk("R8 no error at exactly full", 32'(irq_err), 32'd0);
    fire(1);
    chk("R8 overflow error irq", 32'(irq_err), 32'd1);
    read_status("R8 still full after overflow", exp_stat(0, 3, DEPTH, 0));
    chk("R9 error cleared", 32'(irq_err), 32'd0);
    for (int i = 0; i < DEPTH; i++) drain("R8 dropped sample absent");

    // clears
    fire(1); fire(1);
    opt_write(8'h27);
    sb.delete(); dcnt = 0;
    chk("R6 data clear", 32'(status), 32'(exp_stat(0, 3, 0, 0)));
    chk("R6 strobe reads 0", 32'(opt_rd_byte), 32'h07);
    opt_write(8'h47);
    pl_n = 0;
    chk("R6 list clear", 32'(status), 32'(exp_stat(0, 0, 0, 0)));
    s0 = starts;
    fire(0);
    chk("R5 R6 empty list ignores trigger", starts, s0);

    // full point list
    for (int i = 0; i <= DEPTH; i++) pl_write(16'(16'h1000 * (i % 16) + 16'h0010 * (15 - (i % 16)) + i));
    chk("R11 R7 list full", 32'(status), 32'(exp_stat(0, DEPTH, 0, 0)));
    prime();
    for (int i = 0; i < DEPTH + 1; i++) fire(1);
    chk("R11 wrap after DEPTH entries", starts, s0 + DEPTH + 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule